// File: doc/BRIEF.md
# Multi-mode SPI master engine

This block is a SPI master that moves one 8-bit word per data command. Each data command names a transfer mode. The mode sets how many data lanes carry the word (1, 2 or 4), whether the link is full duplex with separate out and in pins or half duplex over shared pins, and whether each lane carries one bit per SCK period or one bit on each SCK edge. Chip-select changes are commands in the same stream. A chip-select change takes effect one timer period after it is accepted, which gives the slave setup and hold time around the data.

Commands arrive on a valid/ready stream. `cmd_ready_o` is high only while the engine is idle. Read bytes leave on a response stream as a one-cycle valid pulse. The FIFO behind that stream must always have room, because the stream has no back-pressure. `timer_i` sets the length of each SCK level in system clock cycles, and the SCK level changes at most once per system cycle. The FIFOs, the register wrapper and any flash-mapping logic sit outside the block.

Top module: `spi_mm_master`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are: `cs_n_o` high, `sck_o` low, `dq_oe_o` zero, `dq_o` zero, `cmd_ready_o` high and `rsp_valid_o` low.
- R2: `cmd_kind_i` = 0 selects a data command and 1 selects a chip-select command. For a chip-select command, `cmd_data_i[0]` = 1 drives `cs_n_o` low and 0 drives it high.
- R3: A chip-select command accepted at clock edge E changes `cs_n_o` at edge E+T+1, where T is `timer_i`. `cmd_ready_o` is low in between and is high again from that edge.
- R4: During a data transfer, SCK starts and ends low. Each SCK level lasts T+1 system cycles. `cmd_ready_o` stays low until the edge of the last SCK transition and is high from that edge.
- R5: Mode 0 is full duplex on one lane and sends MSB first. It drives `dq_o[0]` with `dq_oe_o` = 4'b0001 and shifts the next bit after each falling SCK edge. It samples `dq_i[1]` on each rising edge and runs 8 SCK periods. When the write flag is clear it sends all ones.
- R6: Mode 1 is half duplex, 4 lanes, one group per SCK period. It runs 2 periods and sends bits [7:4] first. Lane 0 carries the least significant bit of each group.
- R7: Mode 2 is half duplex, 2 lanes, one group per SCK period. It runs 4 periods and sends bits [7:6] first. Lane 0 carries the least significant bit of each group.
- R8: Mode 3 is half duplex, 4 lanes, one group per SCK edge. It runs 1 SCK period. Bits [7:4] are sampled on the rising edge and bits [3:0] on the falling edge. The second group is presented right after the rising edge.
- R9: In a half-duplex transfer with the write flag set, `dq_oe_o` enables exactly the lanes in use for the whole transfer. With the write flag clear, `dq_oe_o` stays zero. When idle it is zero.
- R10: A response is produced only when the read flag is set. `rsp_valid_o` is a one-cycle pulse in the first cycle that `cmd_ready_o` is high again. `rsp_data_o` holds the sampled byte, with the first sampled group in the top bits.
- R11: Mode ids 4 to 7 behave exactly as mode 0.
- R12: A command presented in the cycle where `cmd_ready_o` returns high is accepted at the next edge. This is true even while `rsp_valid_o` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asynchronous assert, release synchronous to clk |
| timer_i | input | 12 | SCK level length minus one, in system cycles; hold stable during a command |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Engine idle, command accepted on this edge when valid |
| cmd_kind_i | input | 1 | 0 data command, 1 chip-select command |
| cmd_mode_i | input | 3 | Transfer mode id for data commands |
| cmd_data_i | input | 8 | Write byte, or bit 0 as chip-select level request |
| cmd_read_i | input | 1 | Return the sampled byte as a response |
| cmd_write_i | input | 1 | Drive the write byte onto the lanes |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_data_o | output | 8 | Response byte |
| sck_o | output | 1 | SPI clock, idle low |
| cs_n_o | output | 1 | Chip select, active low |
| dq_o | output | 4 | Lane output values, zero where not enabled |
| dq_oe_o | output | 4 | Lane output enables |
| dq_i | input | 4 | Lane input values; lane 1 is the serial input in full duplex |

## Verification
Two events can fall in the same cycle. At the end of a read transfer the response pulse rises together with `cmd_ready_o`. In that same cycle the next command can be handshaked. The bench provokes this by presenting the next command in the very cycle the previous read finishes, with no gap. Its cycle-by-cycle model then expects both the single response pulse with the right byte and a new transfer that starts exactly one edge later. A slave model on `dq_i` serves a different byte per transfer, so that a group order or lane mapping error shows up in the returned data.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

  localparam int DQ_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CSW  = 2'd1,
    ST_XFER = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic       full_dup;
    logic       dual_edge;
    logic [2:0] lanes;
  } mode_cfg_t;

endpackage

// File: rtl/spi_mm_mode_table.sv
module spi_mm_mode_table
  import spi_mm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 3,
  parameter int EDGE_W = 4
) (
  input  logic [MODE_W-1:0] mode_id,
  output mode_cfg_t         cfg,
  output logic [EDGE_W-1:0] last_edge
);

  localparam int BEATS_1 = DATA_W;
  localparam int BEATS_2 = DATA_W / 2;
  localparam int BEATS_4 = DATA_W / 4;

  int beats;

  always_comb begin
    case (mode_id)
      MODE_W'(1): cfg = '{full_dup: 1'b0, dual_edge: 1'b0, lanes: 3'd4};
      MODE_W'(2): cfg = '{full_dup: 1'b0, dual_edge: 1'b0, lanes: 3'd2};
      MODE_W'(3): cfg = '{full_dup: 1'b0, dual_edge: 1'b1, lanes: 3'd4};
      default:    cfg = '{full_dup: 1'b1, dual_edge: 1'b0, lanes: 3'd1};
    endcase
  end

  always_comb begin
    case (cfg.lanes)
      3'd2:    beats = BEATS_2;
      3'd4:    beats = BEATS_4;
      default: beats = BEATS_1;
    endcase
    if (cfg.dual_edge) last_edge = EDGE_W'(beats - 1);
    else               last_edge = EDGE_W'(2 * beats - 1);
  end

endmodule

// File: rtl/spi_mm_timer.sv
module spi_mm_timer #(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [TIMER_W-1:0] limit,
  output logic               tick
);

  logic [TIMER_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == limit);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + TIMER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter
  import spi_mm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic [2:0]        lanes,
  input  logic              full_dup,
  input  logic [DQ_W-1:0]   pins_i,
  output logic [DQ_W-1:0]   grp_o,
  output logic [DATA_W-1:0] rx_next
);

  logic [DATA_W-1:0] tx_q, tx_d, rx_q, tx_shifted, rx_shifted;
  logic [DQ_W-1:0]   in_grp;

  assign in_grp = full_dup ? {{(DQ_W-1){1'b0}}, pins_i[1]} : pins_i;

  always_comb begin
    case (lanes)
      3'd2: begin
        grp_o      = {2'b00, tx_q[DATA_W-1 -: 2]};
        tx_shifted = {tx_q[DATA_W-3:0], 2'b00};
        rx_shifted = {rx_q[DATA_W-3:0], in_grp[1:0]};
      end
      3'd4: begin
        grp_o      = tx_q[DATA_W-1 -: 4];
        tx_shifted = {tx_q[DATA_W-5:0], 4'b0000};
        rx_shifted = {rx_q[DATA_W-5:0], in_grp[3:0]};
      end
      default: begin
        grp_o      = {3'b000, tx_q[DATA_W-1]};
        tx_shifted = {tx_q[DATA_W-2:0], 1'b0};
        rx_shifted = {rx_q[DATA_W-2:0], in_grp[0]};
      end
    endcase
  end

  always_comb begin
    if (load)          tx_d = load_val;
    else if (shift_en) tx_d = tx_shifted;
    else               tx_d = tx_q;
    if (load)           rx_next = '0;
    else if (sample_en) rx_next = rx_shifted;
    else                rx_next = rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_next;
    end
  end

endmodule

// File: rtl/spi_mm_master.sv
module spi_mm_master
  import spi_mm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TIMER_W = 12,
  parameter int MODE_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] timer_i,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic               cmd_kind_i,
  input  logic [MODE_W-1:0]  cmd_mode_i,
  input  logic [DATA_W-1:0]  cmd_data_i,
  input  logic               cmd_read_i,
  input  logic               cmd_write_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic               sck_o,
  output logic               cs_n_o,
  output logic [DQ_W-1:0]    dq_o,
  output logic [DQ_W-1:0]    dq_oe_o,
  input  logic [DQ_W-1:0]    dq_i
);

  localparam int EDGE_W = $clog2(2 * DATA_W);

  eng_state_t        state_q, state_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              rd_q, rd_d, wr_q, wr_d, csarg_q, csarg_d;
  logic              rsp_v_q, rsp_v_d;
  logic [DATA_W-1:0] rsp_q;
  logic              rsp_en;

  logic              accept, tick, run, in_xfer, end_edge;
  logic              load, shift_en, sample_en;
  mode_cfg_t         cfg;
  logic [EDGE_W-1:0] last_edge;
  logic [DQ_W-1:0]   lane_mask, oe, grp;
  logic [DATA_W-1:0] rx_next, tx_load;

  spi_mm_mode_table #(.DATA_W(DATA_W), .MODE_W(MODE_W), .EDGE_W(EDGE_W)) u_table (
    .mode_id   (mode_q),
    .cfg       (cfg),
    .last_edge (last_edge)
  );

  assign run = (state_q != ST_IDLE);

  spi_mm_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .limit (timer_i),
    .tick  (tick)
  );

  assign accept    = cmd_valid_i && (state_q == ST_IDLE);
  assign in_xfer   = (state_q == ST_XFER);
  assign end_edge  = in_xfer && tick && (edge_q == last_edge);
  assign load      = accept && !cmd_kind_i;
  assign tx_load   = cmd_write_i ? cmd_data_i : {DATA_W{1'b1}};
  assign sample_en = in_xfer && tick && (cfg.dual_edge || !edge_q[0]);
  assign shift_en  = in_xfer && tick && (cfg.dual_edge ||  edge_q[0]);

  spi_mm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_val  (tx_load),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .lanes     (cfg.lanes),
    .full_dup  (cfg.full_dup),
    .pins_i    (dq_i),
    .grp_o     (grp),
    .rx_next   (rx_next)
  );

  always_comb begin
    case (cfg.lanes)
      3'd2:    lane_mask = 4'b0011;
      3'd4:    lane_mask = 4'b1111;
      default: lane_mask = 4'b0001;
    endcase
    if (!in_xfer)          oe = '0;
    else if (cfg.full_dup) oe = 4'b0001;
    else if (wr_q)         oe = lane_mask;
    else                   oe = '0;
  end

  for (genvar ln = 0; ln < DQ_W; ln++) begin : g_lane
    assign dq_o[ln]    = grp[ln] & oe[ln];
    assign dq_oe_o[ln] = oe[ln];
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    edge_d  = edge_q;
    mode_d  = mode_q;
    rd_d    = rd_q;
    wr_d    = wr_q;
    csarg_d = csarg_q;
    rsp_v_d = 1'b0;
    rsp_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cmd_kind_i) begin
            state_d = ST_CSW;
            csarg_d = cmd_data_i[0];
          end else begin
            state_d = ST_XFER;
            mode_d  = cmd_mode_i;
            rd_d    = cmd_read_i;
            wr_d    = cmd_write_i;
            edge_d  = '0;
          end
        end
      end
      ST_CSW: begin
        if (tick) begin
          state_d = ST_IDLE;
          cs_n_d  = !csarg_q;
        end
      end
      ST_XFER: begin
        if (tick) begin
          sck_d  = !sck_q;
          edge_d = edge_q + EDGE_W'(1);
          if (end_edge) begin
            state_d = ST_IDLE;
            sck_d   = 1'b0;
            edge_d  = '0;
            rsp_v_d = rd_q;
            rsp_en  = rd_q;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      edge_q  <= '0;
      mode_q  <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      csarg_q <= 1'b0;
      rsp_v_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      edge_q  <= edge_d;
      mode_q  <= mode_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      csarg_q <= csarg_d;
      rsp_v_q <= rsp_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_q <= '0;
    else if (rsp_en) rsp_q <= rx_next;
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_v_q;
  assign rsp_data_o  = rsp_q;
  assign sck_o       = sck_q;
  assign cs_n_o      = cs_n_q;

endmodule

// File: rtl/spi_mm_master_chk.sv
module spi_mm_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready_o,
  input logic       rsp_valid_o,
  input logic       sck_o,
  input logic       cs_n_o,
  input logic [3:0] dq_oe_o
);

  // R4
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> !sck_o);

  // R9
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe_o) |-> !cmd_ready_o);

  // R9
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe_o == 4'b0000) || (dq_oe_o == 4'b0001) ||
    (dq_oe_o == 4'b0011) || (dq_oe_o == 4'b1111));

  // R10
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

  // R10
  rsp_at_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> cmd_ready_o);

  // R3
  cs_change_at_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n_o) |-> (cmd_ready_o && !$past(cmd_ready_o)));

endmodule

bind spi_mm_master spi_mm_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready_o (cmd_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .sck_o       (sck_o),
  .cs_n_o      (cs_n_o),
  .dq_oe_o     (dq_oe_o)
);

// File: tb/tb_spi_mm_master.sv
module tb_spi_mm_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] timer_i;
  logic        cmd_valid_i, cmd_ready_o, cmd_kind_i, cmd_read_i, cmd_write_i;
  logic [2:0]  cmd_mode_i;
  logic [7:0]  cmd_data_i, rsp_data_o;
  logic        rsp_valid_o, sck_o, cs_n_o;
  logic [3:0]  dq_o, dq_oe_o, dq_i;

  int errors = 0;
  int checks = 0;
  int tval   = 1;
  logic cs_exp = 1'b1;

  always #2 clk = ~clk;

  spi_mm_master dut (
    .clk(clk), .rst_n(rst_n), .timer_i(timer_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_kind_i(cmd_kind_i), .cmd_mode_i(cmd_mode_i), .cmd_data_i(cmd_data_i),
    .cmd_read_i(cmd_read_i), .cmd_write_i(cmd_write_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .sck_o(sck_o), .cs_n_o(cs_n_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] grp(logic [7:0] b, int lanes, int g);
    int v;
    v = (int'(b) >> (8 - lanes * (g + 1))) & ((1 << lanes) - 1);
    return v[3:0];
  endfunction

  task automatic idle_chk(string req);
    chk(req, "ready", int'(cmd_ready_o), 1);
    chk(req, "sck", int'(sck_o), 0);
    chk(req, "oe", int'(dq_oe_o), 0);
    chk(req, "dq_o", int'(dq_o), 0);
    chk(req, "rsp_valid", int'(rsp_valid_o), 0);
    chk(req, "cs_n", int'(cs_n_o), int'(cs_exp));
  endtask

  // R2 R3: chip-select command, reference timeline
  task automatic run_cs(bit asrt);
    cmd_kind_i = 1'b1; cmd_data_i = {7'b0, asrt}; cmd_valid_i = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= tval + 1; k++) begin
      @(negedge clk);
      if (k == 0) cmd_valid_i = 1'b0;
      if (k <= tval) begin
        chk("R3", "cs_n hold", int'(cs_n_o), int'(cs_exp));
        chk("R3", "ready busy", int'(cmd_ready_o), 0);
      end else begin
        cs_exp = !asrt;
        chk("R2", "cs_n level", int'(cs_n_o), int'(cs_exp));
        chk("R3", "ready back", int'(cmd_ready_o), 1);
      end
    end
  endtask

  // R4..R12: data command, cycle-by-cycle reference
  task automatic run_data(int mode, logic [7:0] tx, bit rd, bit wr, logic [7:0] slv);
    bit   full, ddr;
    int   lanes, beats, edges, per, n, g;
    logic [7:0] txb;
    logic [3:0] mask, exp_oe, exp_o, drv;
    string rq;
    full = 1'b0; ddr = 1'b0; lanes = 1;
    case (mode)
      1: lanes = 4;
      2: lanes = 2;
      3: begin lanes = 4; ddr = 1'b1; end
      default: full = 1'b1;
    endcase
    case (mode)
      0: rq = "R5";
      1: rq = "R6";
      2: rq = "R7";
      3: rq = "R8";
      default: rq = "R11";
    endcase
    beats = 8 / lanes;
    edges = ddr ? beats : 2 * beats;
    per   = tval + 1;
    mask  = 4'((1 << lanes) - 1);
    txb   = (full && !wr) ? 8'hFF : tx;
    cmd_kind_i = 1'b0; cmd_mode_i = 3'(mode); cmd_data_i = tx;
    cmd_read_i = rd; cmd_write_i = wr; cmd_valid_i = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= edges * per; k++) begin
      @(negedge clk);
      if (k == 0) cmd_valid_i = 1'b0;
      n = k / per;
      if (k < edges * per) begin
        g = ddr ? n : n / 2;
        if (full) begin
          exp_oe = 4'b0001;
          exp_o  = grp(txb, 1, g);
          drv    = {2'b00, grp(slv, 1, g)[0], 1'b0};
        end else begin
          exp_oe = wr ? mask : 4'b0000;
          exp_o  = wr ? grp(tx, lanes, g) : 4'b0000;
          drv    = grp(slv, lanes, g);
        end
        chk("R4", "sck level", int'(sck_o), n % 2);
        chk("R4", "ready busy", int'(cmd_ready_o), 0);
        chk(rq, "dq_o group", int'(dq_o), int'(exp_o));
        chk(full ? rq : "R9", "dq_oe", int'(dq_oe_o), int'(exp_oe));
        chk("R10", "no early rsp", int'(rsp_valid_o), 0);
        chk("R2", "cs_n steady", int'(cs_n_o), int'(cs_exp));
        dq_i = drv;
      end else begin
        chk("R4", "ready end", int'(cmd_ready_o), 1);
        chk("R4", "sck end low", int'(sck_o), 0);
        chk("R9", "oe end", int'(dq_oe_o), 0);
        chk("R10", "rsp_valid", int'(rsp_valid_o), int'(rd));
        if (rd) chk(rq, "rsp_data", int'(rsp_data_o), int'(slv));
        dq_i = 4'b0000;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; timer_i = 12'd1; cmd_valid_i = 1'b0; cmd_kind_i = 1'b0;
    cmd_mode_i = '0; cmd_data_i = '0; cmd_read_i = 1'b0; cmd_write_i = 1'b0;
    dq_i = '0;
    repeat (3) @(negedge clk);
    idle_chk("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_chk("R1");

    tval = 1; timer_i = 12'(tval);
    run_cs(1'b1);
    // R12: commands below follow each other with no gap, the response of a
    // read overlaps the acceptance of the next command
    run_data(0, 8'hA5, 1'b1, 1'b1, 8'h3C);
    run_data(1, 8'h96, 1'b0, 1'b1, 8'h00);
    run_data(1, 8'h00, 1'b1, 1'b0, 8'hC3);
    run_data(2, 8'hB4, 1'b0, 1'b1, 8'h00);
    run_data(2, 8'h00, 1'b1, 1'b0, 8'h6D);
    run_data(3, 8'h5A, 1'b0, 1'b1, 8'h00);
    run_data(3, 8'h00, 1'b1, 1'b0, 8'hE1);
    run_data(5, 8'h81, 1'b1, 1'b1, 8'h7E);
    run_data(7, 8'h42, 1'b1, 1'b1, 8'h99);
    run_data(0, 8'h00, 1'b1, 1'b0, 8'h0F);
    run_cs(1'b0);
    @(negedge clk);
    idle_chk("R2");

    tval = 0; timer_i = 12'(tval);
    run_cs(1'b1);
    run_data(0, 8'h3C, 1'b1, 1'b1, 8'hD2);
    run_data(3, 8'h00, 1'b1, 1'b0, 8'h4B);
    run_data(2, 8'h1E, 1'b0, 1'b1, 8'h00);

    tval = 3; timer_i = 12'(tval);
    run_data(2, 8'h00, 1'b1, 1'b0, 8'hA7);
    run_data(1, 8'hF0, 1'b1, 1'b1, 8'h5C);
    run_cs(1'b0);
    repeat (2) @(negedge clk);
    idle_chk("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule